// File: doc/BRIEF.md
# I2C Controller Event Status and Interrupt Vector Unit

This block collects the seven event flags of an I2C master controller and presents them to a processor through three 16-bit registers and one interrupt line. The seven events are: lost arbitration, not-acknowledged, register access ready, receive ready, transmit ready, stop condition seen, and own address matched. Each event arrives from the bus engine as a one-cycle pulse and sets a sticky flag. Software clears a flag either by writing 1 to its bit in the status register or by reading the vector register.

The vector register returns the code of the most urgent pending event that is enabled in the mask. Reading it also clears the flag it reports, so an interrupt handler can read the vector in a loop until it returns zero and handle every event in priority order. Two live levels from the bus engine also appear in the status word: bus busy and receive shift register full.

Top module: `i2c_evt_vector`

## Requirements
- R1: After reset the mask and all event flags are zero, `irq` is low, and the vector register reads 0.
- R2: A pulse on `evt_pulse[i]` sets flag i. The flag is visible in status bit i from the next cycle. The bit order is: 0 lost arbitration, 1 not-acknowledged, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 own address matched.
- R3: A write to status at offset 0x08 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If an event pulse arrives in the same cycle as a clear of the same flag, the flag is set. The clear can come from a status write or from a vector read.
- R5: The mask register at offset 0x04 holds bits 6:0, with mask bit i enabling event i. Bits 15:7 read 0. Only a write to offset 0x04 changes the mask.
- R6: The vector register at offset 0x28 returns i+1 for the lowest index i whose flag and mask bit are both 1. It returns 0 when no such index exists. A flag that is masked off never appears in the vector.
- R7: Reading the vector register clears only the flag it reports. Repeated reads return the enabled codes in rising order and then 0. A read that returns 0 changes no flag.
- R8: `irq` is high exactly when at least one flag is set and enabled. Changing the mask alone changes `irq` in the next cycle.
- R9: Status bit 12 follows `bus_busy` and status bit 11 follows `rx_shift_full` in the same cycle. Writes to the status register cannot change these two bits.
- R10: Writes to the vector offset are ignored. Reads from any offset other than 0x04, 0x08 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 7 | One-cycle event pulses from the bus engine |
| bus_busy | input | 1 | Live bus busy level |
| rx_shift_full | input | 1 | Live receive shift register full level |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; enables the clearing side effect of a vector read |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
A flag stuck at 1 shows up in three places: in the status word on the next read, in a vector read that reports the wrong code, and as an `irq` that stays high after the vector has run out. A stuck clear shows up as an event that never appears in status. A priority encoder that selects the wrong index shows up on the first read with more than one pending event. A lost clear on a vector read makes the next read repeat the same code instead of moving to the next one. Each of these errors is visible within one or two register accesses of the event that triggers it.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EVT   = 7;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 8;
  localparam int CODE_W    = $clog2(NUM_EVT + 1);
  localparam int BIT_RSFUL = 11;
  localparam int BIT_BUSY  = 12;

  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h28;

  typedef enum logic [CODE_W-1:0] {
    EV_NONE = 3'd0, EV_ARB = 3'd1, EV_NAK = 3'd2, EV_ACC = 3'd3,
    EV_RX   = 3'd4, EV_TX  = 3'd5, EV_STOP = 3'd6, EV_SLV = 3'd7
  } evt_code_e;

  // code of the lowest set index (index + 1), zero when nothing is set
  function automatic logic [CODE_W-1:0] lowest_code(input logic [NUM_EVT-1:0] pend);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

  function automatic logic [NUM_EVT-1:0] code_to_onehot(input logic [CODE_W-1:0] c);
    logic [NUM_EVT-1:0] oh;
    oh = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (c == CODE_W'(i + 1)) oh[i] = 1'b1;
    end
    return oh;
  endfunction
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;   // a new event dominates a clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc
  import i2c_evt_pkg::*;
(
  input  logic [NUM_EVT-1:0] pend_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [NUM_EVT-1:0] grant_o
);
  always_comb begin
    code_o  = lowest_code(pend_i);
    grant_o = code_to_onehot(code_o);
  end
endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector
  import i2c_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               bus_busy,
  input  logic               rx_shift_full,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq
);
  logic [NUM_EVT-1:0] flags_q;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] pend_en;
  logic [NUM_EVT-1:0] vec_grant;
  logic [NUM_EVT-1:0] clr_req;
  logic [CODE_W-1:0]  vec_code;
  logic [REG_W-1:0]   stat_word;
  logic               wr_stat, wr_mask, rd_vec;

  assign wr_stat = wr_en && (addr == OFS_STAT);
  assign wr_mask = wr_en && (addr == OFS_MASK);
  assign rd_vec  = rd_en && (addr == OFS_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[NUM_EVT-1:0];
  end

  assign pend_en = flags_q & mask_q;

  evt_prio_enc u_enc (
    .pend_i (pend_en),
    .code_o (vec_code),
    .grant_o(vec_grant)
  );

  always_comb begin
    clr_req = '0;
    if (wr_stat) clr_req = clr_req | wdata[NUM_EVT-1:0];
    if (rd_vec)  clr_req = clr_req | vec_grant;
  end

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (clr_req),
    .flags_o(flags_q)
  );

  always_comb begin
    stat_word                  = '0;
    stat_word[NUM_EVT-1:0]     = flags_q;
    stat_word[BIT_RSFUL]       = rx_shift_full;
    stat_word[BIT_BUSY]        = bus_busy;
  end

  always_comb begin
    case (addr)
      OFS_MASK: rdata = {{(REG_W-NUM_EVT){1'b0}}, mask_q};
      OFS_STAT: rdata = stat_word;
      OFS_VEC:  rdata = {{(REG_W-CODE_W){1'b0}}, vec_code};
      default:  rdata = '0;
    endcase
  end

  assign irq = |pend_en;
endmodule

// File: rtl/i2c_evt_vector_chk.sv
module i2c_evt_vector_chk
  import i2c_evt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wdata,
  input logic               irq,
  input logic [NUM_EVT-1:0] flags,
  input logic [NUM_EVT-1:0] mask,
  input logic [CODE_W-1:0]  code,
  input logic [NUM_EVT-1:0] grant
);
  // R2, R4: a pulsed flag is set next cycle whatever clear came with it
  a_r4_event_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((flags & $past(evt_pulse)) == $past(evt_pulse)));

  // R3: a status write with no competing source leaves exactly the zero-bits
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == OFS_STAT && evt_pulse == '0)
      |=> (flags == ($past(flags) & ~$past(wdata[NUM_EVT-1:0]))));

  // R5: mask moves only on its own write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_MASK) |=> $stable(mask));

  // R6, R8: interrupt and vector agree
  a_r8_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));

  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant != '0) == (code != '0)));

  // R7: the reported flag is gone after the vector read
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_VEC && code != '0 && (evt_pulse & grant) == '0)
      |=> ((flags & $past(grant)) == '0));
endmodule

bind i2c_evt_vector i2c_evt_vector_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_pulse(evt_pulse),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .irq      (irq),
  .flags    (flags_q),
  .mask     (mask_q),
  .code     (vec_code),
  .grant    (vec_grant)
);

// File: tb/i2c_evt_vector_tb.sv
module i2c_evt_vector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_pulse = '0;
  logic        bus_busy = 1'b0;
  logic        rx_shift_full = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

  always #5 clk = ~clk;

  i2c_evt_vector u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .rx_shift_full(rx_shift_full), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {events, mask, expected vector, expected irq}
  localparam int NV = 10;
  localparam logic [17:0] VTAB [NV] = '{
    {7'h7F, 7'h7F, 3'd1, 1'b1},
    {7'h7E, 7'h7F, 3'd2, 1'b1},
    {7'h7F, 7'h7E, 3'd2, 1'b1},
    {7'h60, 7'h7F, 3'd6, 1'b1},
    {7'h40, 7'h40, 3'd7, 1'b1},
    {7'h0F, 7'h70, 3'd0, 1'b0},
    {7'h18, 7'h10, 3'd5, 1'b1},
    {7'h08, 7'h0C, 3'd4, 1'b1},
    {7'h00, 7'h7F, 3'd0, 1'b0},
    {7'h24, 7'h20, 3'd6, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); evt_pulse = v;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic sample_irq(output logic v);
    @(negedge clk); #1 v = irq;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual 0x0000 expected 0x0001");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        q;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
    rd(A_MASK, d); chk("R1 mask", d, 16'h0000);
    rd(A_STAT, d); chk("R1 status", d, 16'h0000);
    rd(A_VEC, d);  chk("R1 vector", d, 16'h0000);

    // table walk: R2, R6, R8
    for (int k = 0; k < NV; k++) begin
      wr(A_STAT, 16'h007F);
      wr(A_MASK, {9'd0, VTAB[k][10:4]});
      pulse(VTAB[k][17:11]);
      rd(A_STAT, d); chk("R2 status bits", d, {9'd0, VTAB[k][17:11]});
      sample_irq(q); chk("R8 irq", {15'd0, q}, {15'd0, VTAB[k][0]});
      // address only, no read strobe: peek vector
      @(negedge clk); addr = A_VEC; #1 d = rdata;
      chk("R6 vector", d, {13'd0, VTAB[k][3:1]});
    end

    // R7: walk all codes by repeated reads
    wr(A_STAT, 16'h007F);
    wr(A_MASK, 16'h007F);
    pulse(7'h7F);
    for (int c = 1; c <= 7; c++) begin
      rd(A_VEC, d); chk("R7 walk", d, 16'(c));
    end
    rd(A_VEC, d); chk("R7 walk end", d, 16'h0000);
    sample_irq(q); chk("R7 irq after walk", {15'd0, q}, 16'h0000);

    // R7: reading zero vector with masked flags pending changes nothing
    wr(A_MASK, 16'h0000);
    pulse(7'h15);
    rd(A_VEC, d); chk("R7 zero read", d, 16'h0000);
    rd(A_STAT, d); chk("R7 flags kept", d, 16'h0015);
    // R8: mask alone raises irq
    wr(A_MASK, 16'h0010);
    sample_irq(q); chk("R8 mask raises irq", {15'd0, q}, 16'h0001);
    wr(A_MASK, 16'h0002);
    sample_irq(q); chk("R8 mask lowers irq", {15'd0, q}, 16'h0000);

    // R3: write-one-to-clear, zero keeps
    wr(A_STAT, 16'h007F);
    pulse(7'h7F);
    wr(A_STAT, 16'h0024);
    rd(A_STAT, d); chk("R3 w1c", d, 16'h005B);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d); chk("R3 zero keeps", d, 16'h005B);

    // R4: set dominates a simultaneous status clear
    wr(A_STAT, 16'h007F);
    @(negedge clk); evt_pulse = 7'h09; wr_en = 1'b1; addr = A_STAT; wdata = 16'h000B;
    @(negedge clk); evt_pulse = '0; wr_en = 1'b0;
    rd(A_STAT, d); chk("R4 set beats write clear", d, 16'h0009);
    // R4: set dominates a simultaneous vector-read clear of same flag
    wr(A_MASK, 16'h007F);
    @(negedge clk); addr = A_VEC; rd_en = 1'b1; evt_pulse = 7'h01; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; evt_pulse = '0;
    chk("R4 read reported", d, 16'h0001);
    rd(A_STAT, d); chk("R4 set beats read clear", d, 16'h0009);

    // R5: mask width
    wr(A_MASK, 16'hFFFF);
    rd(A_MASK, d); chk("R5 mask upper zero", d, 16'h007F);
    wr(A_STAT, 16'hFFFF);
    rd(A_MASK, d); chk("R5 mask unaffected", d, 16'h007F);

    // R9: live levels
    wr(A_STAT, 16'h007F);
    @(negedge clk); bus_busy = 1'b1; rx_shift_full = 1'b1;
    rd(A_STAT, d); chk("R9 live high", d, 16'h1800);
    wr(A_STAT, 16'h1800);
    rd(A_STAT, d); chk("R9 write no effect", d, 16'h1800);
    @(negedge clk); bus_busy = 1'b0;
    rd(A_STAT, d); chk("R9 busy follows", d, 16'h0800);
    @(negedge clk); rx_shift_full = 1'b0;

    // R10: vector write ignored, unmapped reads zero
    pulse(7'h20);
    wr(A_VEC, 16'h0000);
    rd(A_STAT, d); chk("R10 vec write ignored", d, 16'h0020);
    rd(8'h10, d); chk("R10 unmapped", d, 16'h0000);
    rd(A_VEC, d); chk("R10 vector intact", d, 16'h0006);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule